// File: doc/BRIEF.md
# Instruction Cache Tag Directory

This block is the bookkeeping half of an eight-way set-associative instruction cache. For each of 64 sets it stores eight 20-bit address tags with a valid flag and a lock flag per block, plus one opaque replacement-status field per set. A fetch lookup splits a 32-bit address into byte offset, set index and tag. It compares the tag against every block of the indexed set and returns the matching way one cycle later. A fill port writes a tag into a chosen way and marks it valid. A separate port overwrites a set's replacement field. The replacement algorithm itself sits outside this block.

A whole-cache clear request walks the sets one per cycle. It drops every valid flag, including those of locked blocks, and restores each replacement field to its start value. For all 64 cycles of that walk the block holds the CPU with a stall output. Lookups, fills and replacement writes are suppressed while the walk runs.

A 64 KB read-only window, placed by a programmable 16-bit base, exposes the directory to 32-bit loads for debug. Bit 15 of the load address chooses between a tag word and a replacement-status word. Only the CPU master gets data back. Reserved set numbers read as zero. Stores to the window do nothing. A load that collides with a clear is flagged as an error.

Top module: `icache_tagdir`

## Requirements
- R1: A lookup (lk_req) uses lk_addr[11:6] as the set and lk_addr[31:12] as the tag. One cycle later lk_rvalid is high, and lk_hit/lk_way report the lowest-numbered valid way whose tag matches. lk_way is 0 on a miss.
- R2: A fill writes tag fill_addr[31:12] into way fill_way of set fill_addr[11:6] and sets its valid flag. It sets the lock flag to fill_lock. Lookups issued from the next cycle on see the new block.
- R3: The stall output rises in the cycle after an accepted iclr_req and stays high for exactly 64 cycles. An iclr_req that arrives while stall is high is ignored.
- R4: At the end of a clear, every valid flag is 0, including those of locked blocks. Lock flags and tags are kept, and every set's replacement field equals LRU_INIT (default 0x155).
- R5: While stall is high, lookups report a miss. Fills and replacement writes are ignored while stall is high and in the cycle iclr_req is high.
- R6: A load (mm_req=1, mm_we=0) with mm_addr[31:16] equal to mm_base gets mm_rvalid high one cycle later. A load outside the window gets no response.
- R7: With mm_addr[15]=0, the set is mm_addr[13:5] and the way is mm_addr[4:2]. The response holds the tag in bits 31..12, the lock flag in bit 1, the valid flag in bit 0, and zeros elsewhere.
- R8: With mm_addr[15]=1, the response carries the replacement field of set mm_addr[13:5] in bits 9..0, with zeros above. The field is written by lru_we/lru_set/lru_wdata.
- R9: A window load that names a set from 64 to 511 returns zero data.
- R10: A store into the window (mm_we=1) produces no response and changes no directory state.
- R11: A window load from any master other than 0 (the CPU) gets a response with zero data.
- R12: A window load issued in the same cycle as iclr_req, or while stall is high, returns zero data with mm_err high in its response cycle.
- R13: After reset, every block is invalid and unlocked with tag 0, every replacement field equals LRU_INIT, and stall, lk_rvalid, lk_hit, mm_rvalid and mm_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Fetch address to look up |
| lk_rvalid | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| lk_way | output | 3 | Way that hit |
| fill_en | input | 1 | Fill a block |
| fill_addr | input | 32 | Address whose tag is filled |
| fill_way | input | 3 | Way to fill |
| fill_lock | input | 1 | Lock flag for the filled block |
| lru_we | input | 1 | Replacement field write |
| lru_set | input | 6 | Set whose replacement field is written |
| lru_wdata | input | 10 | New replacement field |
| iclr_req | input | 1 | Whole-cache clear request |
| stall | output | 1 | CPU stall while the clear runs |
| mm_req | input | 1 | Memory-mapped access request |
| mm_we | input | 1 | 1 = store, 0 = load |
| mm_addr | input | 32 | Access address |
| mm_master | input | 2 | Requesting master, 0 = CPU |
| mm_base | input | 16 | Upper address bits of the debug window |
| mm_rvalid | output | 1 | Load response valid |
| mm_rdata | output | 32 | Load response data |
| mm_err | output | 1 | Load collided with a clear |

## Verification
Lookup results, load responses and the error flag are all due one cycle after the request. Stall rises one cycle after the clear request and falls 64 cycles later. A fill or replacement write takes effect for any request made in a later cycle. The bench drives inputs on the falling edge and keeps a behavioural model that is updated at each rising edge. It compares every output at the next falling edge, which is the first point at which the registered result is stable. Directed sequences also count stall cycles and read back state through the window after each clear, store or suppressed write.

// File: rtl/icache_tagdir_pkg.sv
// Shared constants and types for the instruction cache tag directory.
package icache_tagdir_pkg;
    localparam int ADDR_W   = 32;
    localparam int WIN_HI_W = 16;

    // Which directory word a window load selects (address bit just below the window base).
    typedef enum logic {
        RD_TAG = 1'b0,
        RD_LRU = 1'b1
    } rd_sel_e;
endpackage

// File: rtl/tagdir_clear_seq.sv
// Whole-cache clear sequencer.
// Starts on a request while idle and then presents one set index per cycle,
// from 0 up to SETS-1. busy is high for exactly SETS cycles.
// Assumes: start is ignored while busy.
module tagdir_clear_seq #(
    parameter int SETS  = 64,
    parameter int SET_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic [SET_W-1:0] clr_set
);
    logic [SET_W-1:0] cnt_q;

    // Advance the walk one set per cycle and stop after the last set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                cnt_q <= '0;
            end
        end else begin
            if (cnt_q == SET_W'(SETS - 1)) begin
                busy <= 1'b0;
            end
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign clr_set = cnt_q;
endmodule

// File: rtl/tagdir_store.sv
// Directory storage: tag, valid and lock per block, and a replacement field per set.
// Provides a combinational tag compare for one set and a random read port.
// Assumes: the caller gates writes so that a clear and a write never overlap.
module tagdir_store #(
    parameter int SETS  = 64,
    parameter int WAYS  = 8,
    parameter int SET_W = 6,
    parameter int WAY_W = 3,
    parameter int TAG_W = 20,
    parameter int LRU_W = 10,
    parameter logic [LRU_W-1:0] LRU_INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_en,
    input  logic [SET_W-1:0] fill_set,
    input  logic [WAY_W-1:0] fill_way,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             fill_lock,
    input  logic             lru_we,
    input  logic [SET_W-1:0] lru_set,
    input  logic [LRU_W-1:0] lru_wdata,
    input  logic             clr_en,
    input  logic [SET_W-1:0] clr_set,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [WAY_W-1:0] lk_way,
    input  logic [SET_W-1:0] rd_set,
    input  logic [WAY_W-1:0] rd_way,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_lock,
    output logic [LRU_W-1:0] rd_lru
);
    logic [TAG_W-1:0] tag_q  [SETS][WAYS];
    logic [WAYS-1:0]  val_q  [SETS];
    logic [WAYS-1:0]  lock_q [SETS];
    logic [LRU_W-1:0] lru_q  [SETS];
    logic [WAYS-1:0]  match;

    // Reset, clear one set, fill one block and update one replacement field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                val_q[s]  <= '0;
                lock_q[s] <= '0;
                lru_q[s]  <= LRU_INIT;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w] <= '0;
                end
            end
        end else begin
            if (clr_en) begin
                val_q[clr_set] <= '0;
                lru_q[clr_set] <= LRU_INIT;
            end
            if (fill_en) begin
                tag_q[fill_set][fill_way]  <= fill_tag;
                val_q[fill_set][fill_way]  <= 1'b1;
                lock_q[fill_set][fill_way] <= fill_lock;
            end
            if (lru_we) begin
                lru_q[lru_set] <= lru_wdata;
            end
        end
    end

    // One comparator per way of the looked-up set.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = val_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    end

    // Pick the lowest matching way.
    always_comb begin
        lk_hit = 1'b0;
        lk_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                lk_hit = 1'b1;
                lk_way = WAY_W'(w);
            end
        end
    end

    assign rd_tag   = tag_q[rd_set][rd_way];
    assign rd_valid = val_q[rd_set][rd_way];
    assign rd_lock  = lock_q[rd_set][rd_way];
    assign rd_lru   = lru_q[rd_set];
endmodule

// File: rtl/tagdir_mmio.sv
// Read-only debug window onto the directory.
// Decodes window loads, applies the master, reserved-set and clear-collision
// rules, and registers a one-cycle response. Stores never respond.
// Assumes: mm_base is stable while requests are in flight.
module tagdir_mmio
    import icache_tagdir_pkg::*;
#(
    parameter int SETS      = 64,
    parameter int SET_W     = 6,
    parameter int WAY_W     = 3,
    parameter int TAG_W     = 20,
    parameter int LRU_W     = 10,
    parameter int WIN_SET_W = 9,
    parameter int MASTER_W  = 2,
    parameter logic [MASTER_W-1:0] CPU_ID = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mm_req,
    input  logic                mm_we,
    input  logic [ADDR_W-1:0]   mm_addr,
    input  logic [MASTER_W-1:0] mm_master,
    input  logic [WIN_HI_W-1:0] mm_base,
    input  logic                iclr_req,
    input  logic                busy,
    output logic [SET_W-1:0]    rd_set,
    output logic [WAY_W-1:0]    rd_way,
    input  logic [TAG_W-1:0]    rd_tag,
    input  logic                rd_valid,
    input  logic                rd_lock,
    input  logic [LRU_W-1:0]    rd_lru,
    output logic                mm_rvalid,
    output logic [ADDR_W-1:0]   mm_rdata,
    output logic                mm_err
);
    localparam int WAY_LO  = 2;
    localparam int SET_LO  = WAY_LO + WAY_W;
    localparam int SET_HI  = SET_LO + WIN_SET_W - 1;
    localparam int WIN_LO  = ADDR_W - WIN_HI_W;
    localparam int SEL_BIT = WIN_LO - 1;

    logic                 in_win, is_read, conflict, reserved, allowed;
    logic [WIN_SET_W-1:0] win_set;
    rd_sel_e              sel;
    logic [ADDR_W-1:0]    word;
    logic                 unused_addr_bits;

    assign in_win   = (mm_addr[ADDR_W-1:WIN_LO] == mm_base);
    assign is_read  = mm_req && !mm_we && in_win;
    assign sel      = rd_sel_e'(mm_addr[SEL_BIT]);
    assign win_set  = mm_addr[SET_HI:SET_LO];
    assign reserved = (32'(win_set) >= SETS);
    assign conflict = iclr_req || busy;
    assign allowed  = (mm_master == CPU_ID) && !reserved && !conflict;
    assign rd_set   = win_set[SET_W-1:0];
    assign rd_way   = mm_addr[SET_LO-1:WAY_LO];
    assign unused_addr_bits = ^{mm_addr[SEL_BIT-1:SET_HI+1], mm_addr[WAY_LO-1:0]};

    // Format the selected directory word.
    always_comb begin
        if (sel == RD_LRU) begin
            word = {{(ADDR_W - LRU_W){1'b0}}, rd_lru};
        end else begin
            word = {rd_tag, {(ADDR_W - TAG_W - 2){1'b0}}, rd_lock, rd_valid};
        end
    end

    // Register the response one cycle after a window load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mm_rvalid <= 1'b0;
            mm_rdata  <= '0;
            mm_err    <= 1'b0;
        end else begin
            mm_rvalid <= is_read;
            mm_err    <= is_read && conflict;
            mm_rdata  <= (is_read && allowed) ? word : '0;
        end
    end
endmodule

// File: rtl/icache_tagdir.sv
// Top of the instruction cache tag directory.
// Splits fetch addresses, gates fills and replacement writes around the clear
// walk, registers lookup results and joins storage, clear walk and debug window.
// Assumes: at most one fill and one replacement write per cycle.
module icache_tagdir
    import icache_tagdir_pkg::*;
#(
    parameter int WAYS      = 8,
    parameter int SET_W     = 6,
    parameter int OFFS_W    = 6,
    parameter int LRU_W     = 10,
    parameter logic [LRU_W-1:0] LRU_INIT = 10'h155,
    parameter int WIN_SET_W = 9,
    parameter int MASTER_W  = 2,
    parameter logic [MASTER_W-1:0] CPU_ID = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lk_req,
    input  logic [ADDR_W-1:0]     lk_addr,
    output logic                  lk_rvalid,
    output logic                  lk_hit,
    output logic [$clog2(WAYS)-1:0] lk_way,
    input  logic                  fill_en,
    input  logic [ADDR_W-1:0]     fill_addr,
    input  logic [$clog2(WAYS)-1:0] fill_way,
    input  logic                  fill_lock,
    input  logic                  lru_we,
    input  logic [SET_W-1:0]      lru_set,
    input  logic [LRU_W-1:0]      lru_wdata,
    input  logic                  iclr_req,
    output logic                  stall,
    input  logic                  mm_req,
    input  logic                  mm_we,
    input  logic [ADDR_W-1:0]     mm_addr,
    input  logic [MASTER_W-1:0]   mm_master,
    input  logic [WIN_HI_W-1:0]   mm_base,
    output logic                  mm_rvalid,
    output logic [ADDR_W-1:0]     mm_rdata,
    output logic                  mm_err
);
    localparam int SETS  = 1 << SET_W;
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = ADDR_W - SET_W - OFFS_W;
    localparam int TAG_LO = SET_W + OFFS_W;

    logic             busy, wr_ok;
    logic [SET_W-1:0] clr_set, rd_set;
    logic [WAY_W-1:0] rd_way, cmp_way;
    logic             cmp_hit;
    logic [TAG_W-1:0] rd_tag;
    logic             rd_valid, rd_lock;
    logic [LRU_W-1:0] rd_lru;
    logic             unused_offs;

    assign wr_ok = !busy && !iclr_req;
    assign stall = busy;
    assign unused_offs = ^{lk_addr[OFFS_W-1:0], fill_addr[OFFS_W-1:0]};

    tagdir_clear_seq #(.SETS(SETS), .SET_W(SET_W)) u_clr (
        .clk(clk), .rst_n(rst_n), .start(iclr_req), .busy(busy), .clr_set(clr_set)
    );

    tagdir_store #(
        .SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W),
        .TAG_W(TAG_W), .LRU_W(LRU_W), .LRU_INIT(LRU_INIT)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_en && wr_ok), .fill_set(fill_addr[TAG_LO-1:OFFS_W]),
        .fill_way(fill_way), .fill_tag(fill_addr[ADDR_W-1:TAG_LO]), .fill_lock(fill_lock),
        .lru_we(lru_we && wr_ok), .lru_set(lru_set), .lru_wdata(lru_wdata),
        .clr_en(busy), .clr_set(clr_set),
        .lk_set(lk_addr[TAG_LO-1:OFFS_W]), .lk_tag(lk_addr[ADDR_W-1:TAG_LO]),
        .lk_hit(cmp_hit), .lk_way(cmp_way),
        .rd_set(rd_set), .rd_way(rd_way),
        .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_lock(rd_lock), .rd_lru(rd_lru)
    );

    tagdir_mmio #(
        .SETS(SETS), .SET_W(SET_W), .WAY_W(WAY_W), .TAG_W(TAG_W), .LRU_W(LRU_W),
        .WIN_SET_W(WIN_SET_W), .MASTER_W(MASTER_W), .CPU_ID(CPU_ID)
    ) u_mmio (
        .clk(clk), .rst_n(rst_n),
        .mm_req(mm_req), .mm_we(mm_we), .mm_addr(mm_addr), .mm_master(mm_master),
        .mm_base(mm_base), .iclr_req(iclr_req), .busy(busy),
        .rd_set(rd_set), .rd_way(rd_way),
        .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_lock(rd_lock), .rd_lru(rd_lru),
        .mm_rvalid(mm_rvalid), .mm_rdata(mm_rdata), .mm_err(mm_err)
    );

    // Register the lookup result; the directory answers miss during a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_rvalid <= 1'b0;
            lk_hit    <= 1'b0;
            lk_way    <= '0;
        end else begin
            lk_rvalid <= lk_req;
            lk_hit    <= lk_req && !busy && cmp_hit;
            lk_way    <= (lk_req && !busy && cmp_hit) ? cmp_way : '0;
        end
    end
endmodule

// File: rtl/icache_tagdir_chk.sv
// Protocol checker for the tag directory, attached by bind.
// Tracks the length of each stall run with a counter instead of a long $past.
module icache_tagdir_chk #(
    parameter int SETS = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        iclr_req,
    input logic        stall,
    input logic        lk_req,
    input logic        lk_rvalid,
    input logic        lk_hit,
    input logic        mm_req,
    input logic        mm_we,
    input logic [15:0] mm_win_hi,
    input logic [15:0] mm_base,
    input logic        mm_rvalid,
    input logic [31:0] mm_rdata,
    input logic        mm_err
);
    logic [$clog2(SETS):0] run_len;

    // Count consecutive stall cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (stall) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    assert_lookup_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_rvalid == $past(lk_req));

    assert_stall_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> $past(iclr_req));

    assert_stall_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (32'(run_len) < SETS));

    assert_stall_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> (32'(run_len) == SETS));

    assert_miss_in_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_rvalid && $past(stall)) |-> !lk_hit);

    assert_window_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mm_rvalid |-> $past(mm_req && !mm_we && (mm_win_hi == mm_base)));

    assert_store_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mm_req && mm_we) |-> !mm_rvalid);

    assert_collision_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mm_rvalid |-> (mm_err == $past(iclr_req || stall)));

    assert_err_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mm_err |-> (mm_rdata == 32'd0));
endmodule

bind icache_tagdir icache_tagdir_chk #(.SETS(SETS)) u_chk (
    .clk(clk), .rst_n(rst_n), .iclr_req(iclr_req), .stall(stall),
    .lk_req(lk_req), .lk_rvalid(lk_rvalid), .lk_hit(lk_hit),
    .mm_req(mm_req), .mm_we(mm_we), .mm_win_hi(mm_addr[31:16]), .mm_base(mm_base),
    .mm_rvalid(mm_rvalid), .mm_rdata(mm_rdata), .mm_err(mm_err)
);

// File: tb/sim_icache_tagdir.sv
// Bench for icache_tagdir: behavioural reference model compared every cycle,
// plus directed sequences for clear, window rules and suppressed writes.
module sim_icache_tagdir;
    localparam logic [15:0] BASE = 16'h1BE0;
    localparam logic [9:0]  INIT = 10'h155;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 0, fill_en = 0, fill_lock = 0, lru_we = 0, iclr_req = 0;
    logic        mm_req = 0, mm_we = 0;
    logic [31:0] lk_addr = 0, fill_addr = 0, mm_addr = 0;
    logic [2:0]  fill_way = 0;
    logic [5:0]  lru_set = 0;
    logic [9:0]  lru_wdata = 0;
    logic [1:0]  mm_master = 0;
    logic [15:0] mm_base = BASE;
    logic        lk_rvalid, lk_hit, stall, mm_rvalid, mm_err;
    logic [2:0]  lk_way;
    logic [31:0] mm_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    icache_tagdir u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_addr(lk_addr), .lk_rvalid(lk_rvalid), .lk_hit(lk_hit), .lk_way(lk_way),
        .fill_en(fill_en), .fill_addr(fill_addr), .fill_way(fill_way), .fill_lock(fill_lock),
        .lru_we(lru_we), .lru_set(lru_set), .lru_wdata(lru_wdata),
        .iclr_req(iclr_req), .stall(stall),
        .mm_req(mm_req), .mm_we(mm_we), .mm_addr(mm_addr), .mm_master(mm_master),
        .mm_base(mm_base), .mm_rvalid(mm_rvalid), .mm_rdata(mm_rdata), .mm_err(mm_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [19:0] m_tag [64][8];
    bit          m_val [64][8];
    bit          m_lock[64][8];
    logic [9:0]  m_lru [64];
    bit          m_busy;
    int          m_cnt;
    bit          armed = 0;
    bit          e_lkv, e_hit, e_rv, e_err, e_stall;
    int          e_way;
    logic [31:0] e_rd;
    bit          ob, rd, cf;
    int          s, found, ws, ww;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) begin
                m_lru[i] = INIT;
                for (int j = 0; j < 8; j++) begin
                    m_tag[i][j] = 0; m_val[i][j] = 0; m_lock[i][j] = 0;
                end
            end
            m_busy = 0; m_cnt = 0;
            e_lkv = 0; e_hit = 0; e_way = 0; e_rv = 0; e_err = 0; e_rd = 0; e_stall = 0;
            armed = 1;
        end else begin
            ob = m_busy;
            s = int'(lk_addr[11:6]);
            found = -1;
            for (int w = 0; w < 8; w++)
                if (found < 0 && m_val[s][w] && m_tag[s][w] == lk_addr[31:12]) found = w;
            e_lkv = lk_req;
            e_hit = lk_req && !ob && found >= 0;
            e_way = e_hit ? found : 0;
            rd = mm_req && !mm_we && mm_addr[31:16] == mm_base;
            cf = iclr_req || ob;
            e_rv = rd; e_err = rd && cf; e_rd = 0;
            ws = int'(mm_addr[13:5]); ww = int'(mm_addr[4:2]);
            if (rd && !cf && mm_master == 0 && ws < 64)
                e_rd = mm_addr[15] ? {22'd0, m_lru[ws]}
                                   : {m_tag[ws][ww], 10'd0, m_lock[ws][ww], m_val[ws][ww]};
            if (ob) begin
                for (int w = 0; w < 8; w++) m_val[m_cnt][w] = 0;
                m_lru[m_cnt] = INIT;
                m_cnt++;
                if (m_cnt == 64) m_busy = 0;
            end else if (iclr_req) begin
                m_busy = 1; m_cnt = 0;
            end
            if (!ob && !iclr_req) begin
                if (fill_en) begin
                    m_tag[fill_addr[11:6]][fill_way]  = fill_addr[31:12];
                    m_val[fill_addr[11:6]][fill_way]  = 1;
                    m_lock[fill_addr[11:6]][fill_way] = fill_lock;
                end
                if (lru_we) m_lru[lru_set] = lru_wdata;
            end
            e_stall = m_busy;
        end
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (armed && !done) begin
            chk(lk_rvalid == e_lkv, "R1 lk_rvalid", 32'(lk_rvalid), 32'(e_lkv));
            chk(lk_hit == e_hit, "R1 lk_hit", 32'(lk_hit), 32'(e_hit));
            if (e_hit) chk(lk_way == 3'(e_way), "R1 lk_way", 32'(lk_way), 32'(e_way));
            chk(stall == e_stall, "R3 stall", 32'(stall), 32'(e_stall));
            chk(mm_rvalid == e_rv, "R6 mm_rvalid", 32'(mm_rvalid), 32'(e_rv));
            chk(mm_err == e_err, "R12 mm_err", 32'(mm_err), 32'(e_err));
            chk(mm_rdata == e_rd, "R7 mm_rdata", mm_rdata, e_rd);
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [31:0] tag_a(input int set, input int way);
        return {BASE, 2'b00, 9'(set), 3'(way), 2'b00};
    endfunction
    function automatic logic [31:0] lru_a(input int set);
        return {BASE, 2'b10, 9'(set), 3'b000, 2'b00};
    endfunction

    task automatic do_fill(input logic [31:0] a, input int way, input bit lk);
        @(negedge clk); fill_en = 1; fill_addr = a; fill_way = 3'(way); fill_lock = lk;
        @(negedge clk); fill_en = 0;
    endtask
    task automatic do_lru(input int set, input logic [9:0] v);
        @(negedge clk); lru_we = 1; lru_set = 6'(set); lru_wdata = v;
        @(negedge clk); lru_we = 0;
    endtask
    task automatic do_look(input logic [31:0] a, output bit hit, output int way);
        @(negedge clk); lk_req = 1; lk_addr = a;
        @(negedge clk); hit = lk_hit; way = int'(lk_way); lk_req = 0;
    endtask
    task automatic do_read(input logic [31:0] a, input logic [1:0] m,
                           output logic [31:0] d, output bit rv, output bit er);
        @(negedge clk); mm_req = 1; mm_we = 0; mm_addr = a; mm_master = m;
        @(negedge clk); d = mm_rdata; rv = mm_rvalid; er = mm_err; mm_req = 0; mm_master = 0;
    endtask
    task automatic do_store(input logic [31:0] a, output bit rv);
        @(negedge clk); mm_req = 1; mm_we = 1; mm_addr = a;
        @(negedge clk); rv = mm_rvalid; mm_req = 0; mm_we = 0;
    endtask
    task automatic do_iclr();
        @(negedge clk); iclr_req = 1;
        @(negedge clk); iclr_req = 0;
    endtask
    task automatic wait_idle();
        while (stall) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        bit rv, er, hit;
        int way, n;
        repeat (4) @(negedge clk);
        // R13: reset state
        chk(stall == 0 && lk_hit == 0 && mm_rvalid == 0 && mm_err == 0, "R13 outputs",
            {stall, lk_hit, mm_rvalid, mm_err}, 0);
        rst_n = 1;
        do_read(tag_a(3, 2), 0, d, rv, er);
        chk(d == 0, "R13 tag after reset", d, 0);
        do_read(lru_a(3), 0, d, rv, er);
        chk(d == 32'(INIT), "R13 lru after reset", d, 32'(INIT));
        // R2 / R1: fill then look up
        do_fill(32'hABCDE0C0, 2, 0);
        do_look(32'hABCDE0C4, hit, way);
        chk(hit && way == 2, "R2 fill visible", 32'(way), 2);
        do_look(32'hABCDF0C4, hit, way);
        chk(!hit, "R1 other tag misses", 32'(hit), 0);
        do_fill(32'hABCDE0C0, 6, 0);
        do_look(32'hABCDE0C0, hit, way);
        chk(hit && way == 2, "R1 lowest way wins", 32'(way), 2);
        // R7: tag word format
        do_read(tag_a(3, 2), 0, d, rv, er);
        chk(rv && d == 32'hABCDE001, "R7 tag word", d, 32'hABCDE001);
        // R8: replacement field readback
        do_lru(3, 10'h2F3);
        do_read(lru_a(3), 0, d, rv, er);
        chk(d == 32'h2F3, "R8 lru word", d, 32'h2F3);
        // R9: reserved set
        do_read(tag_a(100, 2), 0, d, rv, er);
        chk(rv && d == 0, "R9 reserved set", d, 0);
        // R11: other master
        do_read(tag_a(3, 2), 1, d, rv, er);
        chk(rv && d == 0, "R11 non-CPU master", d, 0);
        // R6: outside window
        do_read({16'h1BE1, 16'h0060}, 0, d, rv, er);
        chk(!rv, "R6 outside window", 32'(rv), 0);
        // R10: store ignored
        do_store(tag_a(3, 2), rv);
        chk(!rv, "R10 store no response", 32'(rv), 0);
        do_read(tag_a(3, 2), 0, d, rv, er);
        chk(d == 32'hABCDE001, "R10 state unchanged", d, 32'hABCDE001);
        // R4 / R3: clear with a locked block
        do_fill(32'h12345140, 7, 1);
        do_lru(5, 10'h0AA);
        do_iclr();
        n = 0;
        while (stall) begin n++; @(negedge clk); end
        chk(n == 64, "R3 stall length", 32'(n), 64);
        do_read(tag_a(5, 7), 0, d, rv, er);
        chk(d == 32'h12345002, "R4 locked block invalid", d, 32'h12345002);
        do_read(lru_a(5), 0, d, rv, er);
        chk(d == 32'(INIT), "R4 lru restored", d, 32'(INIT));
        do_look(32'h12345140, hit, way);
        chk(!hit, "R4 lookup misses after clear", 32'(hit), 0);
        // R5 / R12: activity during the clear
        do_fill(32'h77777200, 1, 0);
        do_iclr();
        do_look(32'h77777200, hit, way);
        chk(!hit, "R5 miss during stall", 32'(hit), 0);
        do_fill(32'h55555240, 0, 0);
        do_lru(9, 10'h3FF);
        do_read(tag_a(8, 1), 0, d, rv, er);
        chk(rv && er && d == 0, "R12 read during stall", d, 0);
        wait_idle();
        do_look(32'h55555240, hit, way);
        chk(!hit, "R5 fill in stall ignored", 32'(hit), 0);
        do_read(lru_a(9), 0, d, rv, er);
        chk(d == 32'(INIT), "R5 lru write in stall ignored", d, 32'(INIT));
        // R12: read in the same cycle as the request
        do_fill(32'h33333280, 4, 0);
        @(negedge clk); iclr_req = 1; mm_req = 1; mm_we = 0; mm_addr = tag_a(10, 4);
        @(negedge clk); d = mm_rdata; er = mm_err; iclr_req = 0; mm_req = 0;
        chk(er && d == 0, "R12 same-cycle read", d, 0);
        wait_idle();
        // mixed traffic against the model
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            lk_req = $urandom_range(0, 1);
            lk_addr = {20'hA0000 + 20'($urandom_range(0, 2)), 6'($urandom_range(0, 7)), 6'd0};
            fill_en = ($urandom_range(0, 3) == 0);
            fill_addr = {20'hA0000 + 20'($urandom_range(0, 2)), 6'($urandom_range(0, 7)), 6'd0};
            fill_way = 3'($urandom_range(0, 7));
            fill_lock = $urandom_range(0, 1);
            lru_we = ($urandom_range(0, 7) == 0);
            lru_set = 6'($urandom_range(0, 7));
            lru_wdata = 10'($urandom);
            iclr_req = ($urandom_range(0, 199) == 0);
            mm_req = $urandom_range(0, 1);
            mm_we = ($urandom_range(0, 5) == 0);
            mm_master = ($urandom_range(0, 7) == 0) ? 2'd2 : 2'd0;
            mm_addr = $urandom_range(0, 1) ? lru_a($urandom_range(0, 9))
                                           : tag_a($urandom_range(0, 9), $urandom_range(0, 7));
        end
        @(negedge clk);
        lk_req = 0; fill_en = 0; lru_we = 0; iclr_req = 0; mm_req = 0;
        repeat (70) @(negedge clk);
        finish_run();
    end
endmodule